// File: doc/BRIEF.md
# Sequential Signed/Unsigned 32-by-16 Divider

This block divides a 32-bit dividend by a 16-bit divisor, either as unsigned numbers or as two's-complement numbers. A one-cycle `start` pulse captures the operands, a shift-subtract engine then produces one quotient bit per clock, and a final correction cycle sets the result signs and checks the range. A one-cycle `done` pulse ends the operation. The packed result carries the remainder in its upper half and the quotient in its lower half. It is meant to be written back into a 32-bit destination register, and `result_we` qualifies that write.

The result must fit in a 16-bit quotient. When the quotient is too large, the destination is not written and the overflow flag reports the condition. A zero divisor produces no result at all. Instead it raises a trap request, and the surrounding control logic dispatches the trap as exception vector 5. Signed division works on magnitudes and truncates toward zero, so the remainder always takes the sign of the dividend.

Top module: `iter_divider`

## Requirements
- R1: With `is_signed`=0, a completed division with quotient below 65536 gives `result[15:0]` = dividend / divisor and `result[31:16]` = dividend mod divisor, both unsigned, and pulses `result_we` together with `done`.
- R2: With `is_signed`=1, the quotient is truncated toward zero, and the remainder is zero or carries the sign of the dividend; both are 16-bit two's complement in the same fields as R1.
- R3: The quotient does not fit when it exceeds 65535 (unsigned) or falls outside -32768..32767 (signed). Then `flag_v`=1 at `done`, `result_we` stays 0, and `result` keeps its previous value.
- R4: The signed division 0x80000000 / 0xFFFF (most negative dividend by -1) is reported as overflow per R3.
- R5: A divisor of 0 gives `trap_zero`=1 with `done`, `result_we`=0, `flag_v`=0, and `result` unchanged.
- R6: On a written result, `flag_n` equals quotient bit 15, `flag_z` is 1 exactly when the 16-bit quotient is zero, and `flag_v`=0. `flag_c` is 0 at every `done`.
- R7: `done` rises exactly 33 clock edges after the edge that samples `start` and lasts one cycle. `busy` is 1 from the edge after that start edge until `done` rises, and is 0 while `done` is 1.
- R8: A `start` pulse while `busy`=1 is ignored. The running division completes with its own operands and timing, and no extra `done` follows.
- R9: While and right after synchronous reset, `busy`, `done`, `result_we`, `trap_zero` and all flags are 0, and `result` is 0.
- R10: `result_we` and `trap_zero` are 1 only in a cycle where `done` is 1, and never both at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (sampled when not busy) |
| dividend | input | 32 | Dividend |
| divisor | input | 16 | Divisor |
| is_signed | input | 1 | 1 = two's-complement division, 0 = unsigned |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | {remainder, quotient} of the last written division |
| result_we | output | 1 | Write enable for `result` to the destination |
| flag_n | output | 1 | Quotient negative |
| flag_z | output | 1 | Quotient zero |
| flag_v | output | 1 | Quotient overflow |
| flag_c | output | 1 | Carry, always cleared |
| trap_zero | output | 1 | Divide-by-zero trap request |

## Verification
Small unsigned and signed operands in all four sign combinations show whether the quotient truncates toward zero and whether the remainder follows the dividend's sign rather than the divisor's. Operands that put the quotient exactly at the edges of the 16-bit range (65535, 32767, -32768) and one step past them show whether the overflow limit is placed correctly for each mode. Most-negative by -1, the same bit pattern divided unsigned, and zero divisors in both modes show whether the two failure paths are told apart. A start pulse injected mid-run shows whether the engine can be disturbed while it is busy.

// File: rtl/div_pkg.sv
package div_pkg;

    localparam int DVD_W = 32;
    localparam int DVS_W = 16;
    localparam int RES_W = 2 * DVS_W;
    localparam int ITERS = DVD_W;
    localparam int CNT_W = $clog2(ITERS);
    localparam int LAT   = ITERS + 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX
    } div_state_e;

    typedef struct packed {
        logic q_neg;
        logic r_neg;
        logic sgn;
        logic den_zero;
    } div_ctl_t;

    typedef struct packed {
        logic [DVD_W-1:0] num_mag;
        logic [DVS_W-1:0] den_mag;
        div_ctl_t         ctl;
    } div_op_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } div_flags_t;

    function automatic logic [DVD_W-1:0] mag_dvd(input logic [DVD_W-1:0] x, input logic sgn);
        return (sgn && x[DVD_W-1]) ? (~x + 1'b1) : x;
    endfunction

    function automatic logic [DVS_W-1:0] mag_dvs(input logic [DVS_W-1:0] x, input logic sgn);
        return (sgn && x[DVS_W-1]) ? (~x + 1'b1) : x;
    endfunction

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep
    import div_pkg::*;
(
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    input  logic             is_signed,
    output div_op_t          op
);
    always_comb begin
        op.num_mag      = mag_dvd(dividend, is_signed);
        op.den_mag      = mag_dvs(divisor, is_signed);
        op.ctl.sgn      = is_signed;
        op.ctl.q_neg    = is_signed && (dividend[DVD_W-1] ^ divisor[DVS_W-1]);
        op.ctl.r_neg    = is_signed && dividend[DVD_W-1];
        op.ctl.den_zero = (divisor == '0);
    end
endmodule

// File: rtl/div_iter_core.sv
module div_iter_core
    import div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  div_op_t          op_in,
    output logic             busy,
    output logic             fix_now,
    output div_ctl_t         ctl_q,
    output logic [DVD_W-1:0] quo_mag,
    output logic [DVS_W-1:0] rem_mag
);
    div_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic [DVS_W-1:0] den_q;
    logic [DVS_W:0]   part;
    logic [DVS_W:0]   diff;
    logic             fits;

    always_comb begin
        part = {rem_mag, quo_mag[DVD_W-1]};
        diff = part - {1'b0, den_q};
        fits = (part >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            den_q   <= '0;
            ctl_q   <= '0;
            quo_mag <= '0;
            rem_mag <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        quo_mag <= op_in.num_mag;
                        den_q   <= op_in.den_mag;
                        ctl_q   <= op_in.ctl;
                        rem_mag <= '0;
                        cnt     <= '0;
                        st      <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    quo_mag <= {quo_mag[DVD_W-2:0], fits};
                    rem_mag <= fits ? diff[DVS_W-1:0] : part[DVS_W-1:0];
                    cnt     <= cnt + 1'b1;
                    if (cnt == CNT_W'(ITERS - 1)) st <= ST_FIX;
                end
                ST_FIX:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (st != ST_IDLE);
    assign fix_now = (st == ST_FIX);
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix
    import div_pkg::*;
(
    input  div_ctl_t         ctl,
    input  logic [DVD_W-1:0] quo_mag,
    input  logic [DVS_W-1:0] rem_mag,
    output logic [RES_W-1:0] res,
    output logic             ovf,
    output logic             trap,
    output div_flags_t       flags
);
    localparam logic [DVD_W-1:0] HALF = DVD_W'(1) << (DVS_W - 1);

    logic             raw_ovf;
    logic [DVS_W-1:0] q_lo;
    logic [DVS_W-1:0] r_lo;

    always_comb begin
        if (!ctl.sgn)        raw_ovf = |quo_mag[DVD_W-1:DVS_W];
        else if (ctl.q_neg)  raw_ovf = (quo_mag > HALF);
        else                 raw_ovf = (quo_mag >= HALF);

        q_lo = ctl.q_neg ? (~quo_mag[DVS_W-1:0] + 1'b1) : quo_mag[DVS_W-1:0];
        r_lo = ctl.r_neg ? (~rem_mag + 1'b1) : rem_mag;
        res  = {r_lo, q_lo};

        trap    = ctl.den_zero;
        ovf     = !trap && raw_ovf;
        flags.c = 1'b0;
        flags.v = ovf;
        flags.n = !trap && !raw_ovf && q_lo[DVS_W-1];
        flags.z = !trap && !raw_ovf && (q_lo == '0);
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    input  logic             is_signed,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result,
    output logic             result_we,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    output logic             trap_zero
);
    div_op_t          op;
    div_ctl_t         ctl_q;
    logic [DVD_W-1:0] quo_mag;
    logic [DVS_W-1:0] rem_mag;
    logic             fix_now;
    logic [RES_W-1:0] res_nxt;
    logic             ovf_nxt;
    logic             trap_nxt;
    div_flags_t       flags_nxt;
    div_flags_t       flags_q;

    div_operand_prep u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .is_signed(is_signed),
        .op       (op)
    );

    div_iter_core u_core (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .op_in  (op),
        .busy   (busy),
        .fix_now(fix_now),
        .ctl_q  (ctl_q),
        .quo_mag(quo_mag),
        .rem_mag(rem_mag)
    );

    div_result_fix u_fix (
        .ctl    (ctl_q),
        .quo_mag(quo_mag),
        .rem_mag(rem_mag),
        .res    (res_nxt),
        .ovf    (ovf_nxt),
        .trap   (trap_nxt),
        .flags  (flags_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            result_we <= 1'b0;
            trap_zero <= 1'b0;
            result    <= '0;
            flags_q   <= '0;
        end else begin
            done      <= fix_now;
            result_we <= fix_now && !trap_nxt && !ovf_nxt;
            trap_zero <= fix_now && trap_nxt;
            if (fix_now) flags_q <= flags_nxt;
            if (fix_now && !trap_nxt && !ovf_nxt) result <= res_nxt;
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;
endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk
    import div_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [RES_W-1:0] result,
    input logic             result_we,
    input logic             flag_v,
    input logic             flag_c,
    input logic             trap_zero
);
    localparam int RL_W = $clog2(LAT + 2) + 1;
    logic [RL_W-1:0] run_len;

    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R7
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst) !(busy && done));
    p_latency_r7: assert property (@(posedge clk) disable iff (rst) done |-> (run_len == RL_W'(LAT)));
    p_accept_r7: assert property (@(posedge clk) disable iff (rst) (start && !busy) |=> busy);
    // R10
    p_we_in_done_r10: assert property (@(posedge clk) disable iff (rst) result_we |-> (done && !trap_zero));
    p_trap_in_done_r10: assert property (@(posedge clk) disable iff (rst) trap_zero |-> done);
    // R3
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst) (done && flag_v) |-> !result_we);
    p_hold_result_r3: assert property (@(posedge clk) disable iff (rst) !result_we |-> $stable(result));
    // R5
    p_trap_no_v_r5: assert property (@(posedge clk) disable iff (rst) trap_zero |-> !flag_v);
    // R6
    p_carry_clear_r6: assert property (@(posedge clk) disable iff (rst) done |-> !flag_c);
endmodule

bind iter_divider iter_divider_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .result   (result),
    .result_we(result_we),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .trap_zero(trap_zero)
);

// File: tb/iter_divider_tb.sv
module iter_divider_tb;
    import div_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        is_signed = 1'b0;
    logic        busy, done, result_we, flag_n, flag_z, flag_v, flag_c, trap_zero;
    logic [31:0] result;

    iter_divider u_dut (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .is_signed(is_signed), .busy(busy), .done(done), .result(result),
        .result_we(result_we), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .trap_zero(trap_zero)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [31:0] res;
        logic        trap;
        logic        ovf;
        logic        n;
        logic        z;
        longint      due;
        string       req;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    longint      cyc = 0;
    logic [31:0] last_res = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [31:0] a, input logic [15:0] d,
                                   input logic s, input string req);
        exp_t   e;
        longint qa = 0;
        longint ra = 0;
        e.req  = req;
        e.trap = (d == 16'h0);
        e.ovf  = 1'b0;
        if (!e.trap) begin
            if (!s) begin
                qa    = longint'(a) / longint'(d);
                ra    = longint'(a) % longint'(d);
                e.ovf = (qa > 65535);
            end else begin
                qa    = longint'($signed(a)) / longint'($signed(d));
                ra    = longint'($signed(a)) % longint'($signed(d));
                e.ovf = (qa > 32767) || (qa < -32768);
            end
        end
        e.n   = qa[15];
        e.z   = (qa[15:0] == 16'h0);
        e.res = (e.trap || e.ovf) ? last_res : {ra[15:0], qa[15:0]};
        e.due = 0;
        return e;
    endfunction

    task automatic issue(input logic [31:0] a, input logic [15:0] d, input logic s,
                         input string req);
        exp_t e;
        e = model(a, d, s, req);
        if (!e.trap && !e.ovf) last_res = e.res;
        @(negedge clk);
        dividend  = a;
        divisor   = d;
        is_signed = s;
        start     = 1'b1;
        e.due     = cyc + ITERS + 2;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R7", "busy after start", 64'(busy), 64'd1);
    endtask

    task automatic run(input logic [31:0] a, input logic [15:0] d, input logic s,
                       input string req);
        issue(a, d, s, req);
        while (sb.size() != 0) @(negedge clk);
    endtask

    // monitor: pops expected items as the design reports completion
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (result_we && !done) check(0, "R10", "result_we without done", 64'(result_we), 64'd0);
                if (trap_zero && !done) check(0, "R10", "trap without done", 64'(trap_zero), 64'd0);
                if (done) begin
                    if (sb.size() == 0) begin
                        check(0, "R8", "unexpected done", 64'(done), 64'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(cyc == e.due, "R7", "done cycle", 64'(cyc), 64'(e.due));
                        check(busy == 1'b0, "R7", "busy during done", 64'(busy), 64'd0);
                        check(trap_zero == e.trap, "R5", {e.req, " trap"}, 64'(trap_zero), 64'(e.trap));
                        check(result_we == !(e.trap || e.ovf), e.req, "result_we", 64'(result_we),
                              64'(!(e.trap || e.ovf)));
                        check(flag_v == e.ovf, e.req, "flag_v", 64'(flag_v), 64'(e.ovf));
                        check(flag_c == 1'b0, "R6", "flag_c", 64'(flag_c), 64'd0);
                        check(result == e.res, e.req, "result", 64'(result), 64'(e.res));
                        if (!e.trap && !e.ovf) begin
                            check(flag_n == e.n, "R6", "flag_n", 64'(flag_n), 64'(e.n));
                            check(flag_z == e.z, "R6", "flag_z", 64'(flag_z), 64'(e.z));
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({busy, done, result_we, trap_zero, flag_n, flag_z, flag_v, flag_c} == 8'h0,
              "R9", "outputs in reset", 64'({busy, done, result_we, trap_zero,
              flag_n, flag_z, flag_v, flag_c}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(result == 32'h0 && !busy && !done, "R9", "after reset", 64'(result), 64'd0);

        // R1 unsigned
        run(32'd100, 16'd7, 1'b0, "R1");
        run(32'h1234_5678, 16'h9ABC, 1'b0, "R1");
        run(32'h0001_FFFE, 16'd2, 1'b0, "R1");
        run(32'h0000_0000, 16'd5, 1'b0, "R1");
        run(32'h0000_FFFF, 16'd1, 1'b0, "R1");
        // R2 signed, four sign combinations
        run(32'd100, 16'd7, 1'b1, "R2");
        run(-32'sd100, 16'd7, 1'b1, "R2");
        run(32'd100, -16'sd7, 1'b1, "R2");
        run(-32'sd100, -16'sd7, 1'b1, "R2");
        run(-32'sd7, 16'd100, 1'b1, "R2");
        // R3 range edges
        run(32'hFFFF_FFFF, 16'hFFFF, 1'b0, "R3");
        run(32'h0001_0000, 16'd1, 1'b0, "R3");
        run(32'h0000_8000, 16'd1, 1'b1, "R3");
        run(32'h0000_7FFF, 16'd1, 1'b1, "R3");
        run(32'hFFFF_8000, 16'd1, 1'b1, "R3");
        run(32'hFFFF_7FFF, 16'd1, 1'b1, "R3");
        run(32'h0000_8000, 16'hFFFF, 1'b1, "R3");
        // R4 most negative by -1, and the same bits unsigned
        run(32'h8000_0000, 16'hFFFF, 1'b1, "R4");
        run(32'h8000_0000, 16'hFFFF, 1'b0, "R4");
        // R5 zero divisor
        run(32'd1234, 16'd0, 1'b0, "R5");
        run(-32'sd5, 16'd0, 1'b1, "R5");

        // R8 start while busy is ignored
        issue(32'd1000, 16'd10, 1'b0, "R8");
        repeat (5) @(negedge clk);
        dividend  = 32'd999;
        divisor   = 16'd3;
        is_signed = 1'b1;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (40) @(negedge clk);
        check(busy == 1'b0, "R8", "no second run", 64'(busy), 64'd0);
        check(result == 32'h0000_0064, "R8", "result kept", 64'(result), 64'h64);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule